// File: doc/BRIEF.md
# Aperture Address Translator

This block sits between a graphics aperture decoder and system memory. A bus address that falls inside the aperture window is split into a page index and a byte offset. The index selects one 32-bit entry of a remapping table held in system memory. Each entry names the physical 4 KB frame that backs that aperture page. A four-slot fully associative cache holds recently used entries. A hit returns its translation one cycle after the request is taken. A miss reads the entry through a simple memory read port, swaps its byte order, checks its valid flag, and then either fills the cache or reports a fault.

Software programs three registers through a write-only configuration port: the aperture base, the table base with its page count, and a control word. The control word carries enable, invalidate and secondary-reset bits. Software drives these bits with fixed write sequences. A full flush is enable with invalidate, then enable, then enable with reset, then enable. Shutdown is enable with invalidate, then zero, then reset, then zero. Before it shuts the unit down, software polls the idle flag.

Top module: `apx_xlate`

## Requirements
- R1: Configuration writes use `cfg_sel` code 0 for the aperture base, 1 for the table base and 2 for the control word. An address is inside the window when bits 31:28 equal bits 31:28 of the aperture base. An address outside the window is answered one cycle after acceptance with `rsp_inwin`=0, `rsp_fault`=0 and `rsp_paddr` equal to the request address.
- R2: The page index is request bits 27:12. Table base bits 11:0 give the number of 4 KB table pages, and each page holds 1024 entries. An index at or beyond pages×1024 is answered one cycle later with a fault and causes no memory read.
- R3: A miss raises `mem_rd` for exactly one cycle. `mem_addr` then equals (table base bits 31:12 followed by 12 zero bits) plus 4×index.
- R4: The fetched word is byte-swapped: byte 0 of `mem_rdata` becomes bits 31:24. In the swapped word, bit 0 is the valid flag and bits 31:12 are the frame. The translation is that frame followed by request bits 11:0.
- R5: An entry whose valid flag is 0 gives a faulting response and is not cached, so the next access to that page reads memory again.
- R6: A cache hit is answered one cycle after acceptance and causes no memory read.
- R7: The cache holds 4 pages and replaces slots in round-robin order. The fifth distinct page to be filled evicts the first one.
- R8: A control write with bit 0 (invalidate) set empties the cache from the next cycle on.
- R9: A control write with bit 16 (secondary reset) set also empties the cache.
- R10: While control bit 8 (enable) is 0, every in-window request is answered one cycle later with a fault and causes no memory read.
- R11: `stat_idle` is 1 exactly when no table fetch is pending. Requests are accepted only while it is 1.
- R12: A flush that arrives while a fetch is pending still lets that fetch answer normally, but the fetched entry is not cached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 aperture, 1 table, 2 control |
| cfg_wdata | input | 32 | Configuration write data |
| stat_idle | output | 1 | No table fetch pending; request may be presented |
| req_valid | input | 1 | Translation request |
| req_addr | input | 32 | Bus address to translate |
| rsp_valid | output | 1 | Response strobe |
| rsp_fault | output | 1 | Translation failed |
| rsp_inwin | output | 1 | Address was inside the aperture window |
| rsp_paddr | output | 32 | Physical or passed-through address |
| mem_rd | output | 1 | Table entry read request |
| mem_addr | output | 32 | Table entry byte address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data, little-endian entry |

## Verification
The bench sweeps every index of a one-page table and a few indices past its end. This catches an off-by-one limit, which would translate index 1024 or fault on 1023. It also catches a missing byte swap, which gives wrong frames and wrong valid flags. Hit latency and memory-read counts are checked on repeated pages, so an entry that is never cached shows up as extra reads. A fifth distinct page must evict the oldest slot, which a wrong replacement pointer would keep instead. Flushes are placed both between requests and during a pending fetch. A design that still filled the cache after a mid-fetch flush would answer the next access from stale contents without reading memory.

// File: rtl/apx_pkg.sv
package apx_pkg;
  localparam int AW      = 32;
  localparam int WINB    = 4;
  localparam int PGB     = 12;
  localparam int IDXW    = AW - WINB - PGB;
  localparam int FRW     = AW - PGB;
  localparam int CNTW    = PGB;
  localparam int ENT_LOG = PGB - 2;
  localparam int CTL_INV = 0;
  localparam int CTL_EN  = 8;
  localparam int CTL_RST = 16;

  typedef enum logic [1:0] {
    SEL_APER  = 2'd0,
    SEL_TABLE = 2'd1,
    SEL_CTRL  = 2'd2
  } cfg_sel_e;

  function automatic logic [AW-1:0] swap_bytes(input logic [AW-1:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic in_window(input logic [AW-1:0] a, input logic [WINB-1:0] base);
    return a[AW-1:AW-WINB] == base;
  endfunction

  function automatic logic [IDXW-1:0] page_index(input logic [AW-1:0] a);
    return a[AW-WINB-1:PGB];
  endfunction

  function automatic logic index_ok(input logic [IDXW-1:0] idx, input logic [CNTW-1:0] pages);
    return (32'(idx)) < (32'(pages) << ENT_LOG);
  endfunction

  function automatic logic [AW-1:0] entry_addr(input logic [FRW-1:0] tbl, input logic [IDXW-1:0] idx);
    return {tbl, {PGB{1'b0}}} + (AW'(idx) << 2);
  endfunction
endpackage

// File: rtl/apx_cfg.sv
module apx_cfg
  import apx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [AW-1:0]     cfg_wdata,
  output logic [WINB-1:0]   ap_base,
  output logic [FRW-1:0]    tbl_frame,
  output logic [CNTW-1:0]   tbl_pages,
  output logic              en,
  output logic              flush_ev
);
  logic ctl_wr;
  assign ctl_wr   = cfg_we && (cfg_sel == SEL_CTRL);
  assign flush_ev = ctl_wr && (cfg_wdata[CTL_INV] || cfg_wdata[CTL_RST]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ap_base   <= '0;
      tbl_frame <= '0;
      tbl_pages <= '0;
      en        <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_sel)
        SEL_APER:  ap_base <= cfg_wdata[AW-1:AW-WINB];
        SEL_TABLE: begin
          tbl_frame <= cfg_wdata[AW-1:PGB];
          tbl_pages <= cfg_wdata[CNTW-1:0];
        end
        SEL_CTRL:  en <= cfg_wdata[CTL_EN];
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/apx_tlb.sv
module apx_tlb
  import apx_pkg::*;
#(
  parameter int ENTRIES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IDXW-1:0]    lk_idx,
  output logic               lk_hit,
  output logic [FRW-1:0]     lk_frame,
  input  logic               fill,
  input  logic [IDXW-1:0]    fill_idx,
  input  logic [FRW-1:0]     fill_frame,
  input  logic               flush,
  output logic [ENTRIES-1:0] vld_o
);
  localparam int PW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld;
  logic [IDXW-1:0]    tag   [ENTRIES];
  logic [FRW-1:0]     frame [ENTRIES];
  logic [ENTRIES-1:0] match;
  logic [PW-1:0]      ptr;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = vld[g] && (tag[g] == lk_idx);
  end

  always_comb begin
    lk_hit   = |match;
    lk_frame = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (match[i]) lk_frame = lk_frame | frame[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      vld <= '0;
      ptr <= '0;
    end else if (fill) begin
      vld[ptr] <= 1'b1;
      ptr      <= (ptr == PW'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill && !flush) begin
      tag[ptr]   <= fill_idx;
      frame[ptr] <= fill_frame;
    end
  end

  assign vld_o = vld;
endmodule

// File: rtl/apx_walk.sv
module apx_walk
  import apx_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [AW-1:0]  start_addr,
  input  logic           flush,
  output logic           mem_rd,
  output logic [AW-1:0]  mem_addr,
  input  logic           mem_rvalid,
  input  logic [AW-1:0]  mem_rdata,
  output logic           done,
  output logic           done_ok,
  output logic [FRW-1:0] done_frame,
  output logic           done_keep,
  output logic           idle
);
  typedef enum logic [1:0] {W_IDLE, W_ISSUE, W_WAIT} wstate_e;
  wstate_e state;
  logic    stale;
  logic [AW-1:0] word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= W_IDLE;
      mem_addr <= '0;
      stale    <= 1'b0;
    end else begin
      case (state)
        W_IDLE: if (start) begin
          state    <= W_ISSUE;
          mem_addr <= start_addr;
          stale    <= flush;
        end
        W_ISSUE: begin
          state <= W_WAIT;
          if (flush) stale <= 1'b1;
        end
        W_WAIT: begin
          if (flush) stale <= 1'b1;
          if (mem_rvalid) state <= W_IDLE;
        end
        default: state <= W_IDLE;
      endcase
    end
  end

  assign word       = swap_bytes(mem_rdata);
  assign mem_rd     = (state == W_ISSUE);
  assign done       = (state == W_WAIT) && mem_rvalid;
  assign done_ok    = word[0];
  assign done_frame = word[AW-1:PGB];
  assign done_keep  = !stale && !flush;
  assign idle       = (state == W_IDLE);
endmodule

// File: rtl/apx_xlate.sv
module apx_xlate
  import apx_pkg::*;
#(
  parameter int ENTRIES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  output logic          stat_idle,
  input  logic          req_valid,
  input  logic [31:0]   req_addr,
  output logic          rsp_valid,
  output logic          rsp_fault,
  output logic          rsp_inwin,
  output logic [31:0]   rsp_paddr,
  output logic          mem_rd,
  output logic [31:0]   mem_addr,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata
);
  logic [WINB-1:0] ap_base;
  logic [FRW-1:0]  tbl_frame;
  logic [CNTW-1:0] tbl_pages;
  logic            en, flush_ev;

  // named events for the checker
  logic            acc_fire, acc_inwin, acc_en, acc_inrange, acc_hit, acc_walk;
  logic [IDXW-1:0] acc_idx;
  logic [FRW-1:0]  hit_frame;
  logic            walk_done, walk_ok, walk_keep, walk_idle, fill;
  logic [FRW-1:0]  walk_frame;
  logic [ENTRIES-1:0] tlb_vld;
  logic [IDXW-1:0] pend_idx;
  logic [PGB-1:0]  pend_off;

  apx_cfg u_cfg (
    .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_wdata,
    .ap_base, .tbl_frame, .tbl_pages, .en, .flush_ev
  );

  assign acc_fire    = req_valid && walk_idle;
  assign acc_inwin   = in_window(req_addr, ap_base);
  assign acc_idx     = page_index(req_addr);
  assign acc_inrange = index_ok(acc_idx, tbl_pages);
  assign acc_en      = en;
  assign acc_walk    = acc_fire && acc_inwin && acc_en && acc_inrange && !acc_hit;
  assign fill        = walk_done && walk_ok && walk_keep;

  apx_tlb #(.ENTRIES(ENTRIES)) u_tlb (
    .clk, .rst_n,
    .lk_idx(acc_idx), .lk_hit(acc_hit), .lk_frame(hit_frame),
    .fill, .fill_idx(pend_idx), .fill_frame(walk_frame),
    .flush(flush_ev), .vld_o(tlb_vld)
  );

  apx_walk u_walk (
    .clk, .rst_n,
    .start(acc_walk), .start_addr(entry_addr(tbl_frame, acc_idx)),
    .flush(flush_ev),
    .mem_rd, .mem_addr, .mem_rvalid, .mem_rdata,
    .done(walk_done), .done_ok(walk_ok), .done_frame(walk_frame),
    .done_keep(walk_keep), .idle(walk_idle)
  );

  assign stat_idle = walk_idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_idx <= '0;
      pend_off <= '0;
    end else if (acc_walk) begin
      pend_idx <= acc_idx;
      pend_off <= req_addr[PGB-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_inwin <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (walk_done) begin
        rsp_valid <= 1'b1;
        rsp_inwin <= 1'b1;
        rsp_fault <= !walk_ok;
        rsp_paddr <= walk_ok ? {walk_frame, pend_off} : '0;
      end else if (acc_fire && !acc_walk) begin
        rsp_valid <= 1'b1;
        rsp_inwin <= acc_inwin;
        if (!acc_inwin) begin
          rsp_fault <= 1'b0;
          rsp_paddr <= req_addr;
        end else if (!acc_en || !acc_inrange) begin
          rsp_fault <= 1'b1;
          rsp_paddr <= '0;
        end else begin
          rsp_fault <= 1'b0;
          rsp_paddr <= {hit_frame, req_addr[PGB-1:0]};
        end
      end
    end
  end
endmodule

// File: rtl/apx_xlate_chk.sv
module apx_xlate_chk #(
  parameter int ENTRIES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [31:0]        req_addr,
  input logic               acc_fire,
  input logic               acc_inwin,
  input logic               acc_en,
  input logic               acc_inrange,
  input logic               acc_hit,
  input logic               walk_done,
  input logic               walk_ok,
  input logic               flush_ev,
  input logic [ENTRIES-1:0] tlb_vld,
  input logic               stat_idle,
  input logic               mem_rd,
  input logic               rsp_valid,
  input logic               rsp_fault,
  input logic               rsp_inwin,
  input logic [31:0]        rsp_paddr
);
  p_outwin_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire && !acc_inwin |=> rsp_valid && !rsp_fault && !rsp_inwin && rsp_paddr == $past(req_addr));

  p_range_fault_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire && acc_inwin && acc_en && !acc_inrange |=> rsp_valid && rsp_fault && !mem_rd);

  p_rd_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);

  p_bad_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done && !walk_ok |=> rsp_valid && rsp_fault);

  p_hit_fast_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire && acc_inwin && acc_en && acc_inrange && acc_hit |=> rsp_valid && !rsp_fault && !mem_rd);

  p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_ev |=> tlb_vld == '0);

  p_disabled_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire && acc_inwin && !acc_en |=> rsp_valid && rsp_fault && !mem_rd);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stat_idle |-> !mem_rd);
endmodule

bind apx_xlate apx_xlate_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_addr(req_addr),
  .acc_fire(acc_fire), .acc_inwin(acc_inwin), .acc_en(acc_en),
  .acc_inrange(acc_inrange), .acc_hit(acc_hit),
  .walk_done(walk_done), .walk_ok(walk_ok), .flush_ev(flush_ev),
  .tlb_vld(tlb_vld), .stat_idle(stat_idle), .mem_rd(mem_rd),
  .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_inwin(rsp_inwin),
  .rsp_paddr(rsp_paddr)
);

// File: tb/apx_xlate_bench.sv
`timescale 1ns/1ps
module apx_xlate_bench;
  localparam logic [31:0] TBL  = 32'h0010_0000;
  localparam logic [31:0] WIN  = 32'h4000_0000;
  localparam int          NENT = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic        stat_idle;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = 32'd0;
  logic        rsp_valid, rsp_fault, rsp_inwin;
  logic [31:0] rsp_paddr;
  logic        mem_rd;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = 32'd0;

  int checks = 0;
  int failures = 0;
  int rd_count = 0;
  logic [31:0] last_maddr = 32'd0;
  logic        pend = 1'b0;
  logic [31:0] pend_addr = 32'd0;
  logic        r_fault, r_inwin;
  logic [31:0] r_paddr;
  int          lat, nrd;

  always #4 clk = ~clk;

  apx_xlate u_apx_xlate (
    .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_wdata, .stat_idle,
    .req_valid, .req_addr, .rsp_valid, .rsp_fault, .rsp_inwin, .rsp_paddr,
    .mem_rd, .mem_addr, .mem_rvalid, .mem_rdata
  );

  function automatic logic [19:0] frame_of(input int i);
    return 20'((i * 37 + 5) & 32'hFFFFF);
  endfunction

  function automatic logic valid_of(input int i);
    return (i % 7) != 3;
  endfunction

  function automatic logic [31:0] le_word(input int i);
    logic [31:0] w;
    w = {frame_of(i), 11'(i), valid_of(i)};
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  // memory model: one cycle between request and data
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (pend) begin
      mem_rvalid <= 1'b1;
      mem_rdata  <= le_word(int'((pend_addr - TBL) >> 2));
      pend       <= 1'b0;
    end
    if (mem_rd) begin
      pend       <= 1'b1;
      pend_addr  <= mem_addr;
      last_maddr <= mem_addr;
      rd_count   <= rd_count + 1;
    end
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic access(input logic [31:0] a);
    int start;
    @(negedge clk);
    start = rd_count;
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    r_fault = rsp_fault; r_inwin = rsp_inwin; r_paddr = rsp_paddr;
    nrd = rd_count - start;
  endtask

  function automatic logic [31:0] va(input int i, input int off);
    return WIN + (32'(i) << 12) + 32'(off & 12'hFFF);
  endfunction

  task automatic full_flush();
    cfg_write(2'd2, 32'h0000_0101);
    cfg_write(2'd2, 32'h0000_0100);
    cfg_write(2'd2, 32'h0001_0100);
    cfg_write(2'd2, 32'h0000_0100);
  endtask

  task automatic expect_page(input int i, input int off, input string req);
    access(va(i, off));
    check(r_inwin == 1'b1, req, 32'(r_inwin), 32'd1);
    if (i >= NENT || !valid_of(i)) begin
      check(r_fault == 1'b1, req, 32'(r_fault), 32'd1);
    end else begin
      check(r_fault == 1'b0, req, 32'(r_fault), 32'd0);
      check(r_paddr == {frame_of(i), 12'(off)}, "R4", r_paddr, {frame_of(i), 12'(off)});
    end
  endtask

  initial begin
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(stat_idle == 1'b1, "R11", 32'(stat_idle), 32'd1);
    check(rsp_valid == 1'b0, "R11", 32'(rsp_valid), 32'd0);
    check(mem_rd == 1'b0, "R11", 32'(mem_rd), 32'd0);

    cfg_write(2'd0, WIN | 32'h0ABC_DEF0);   // low bits ignored (R1)
    cfg_write(2'd1, TBL | 32'd1);           // one table page

    // R10 disabled
    access(va(2, 0));
    check(r_fault == 1'b1 && nrd == 0, "R10", {31'd0, r_fault}, 32'd1);
    check(lat == 1, "R10", 32'(lat), 32'd1);

    // power-on: flush, enable, flush
    full_flush();
    full_flush();

    // R1 out of window
    access(32'h5000_1234);
    check(r_inwin == 1'b0 && r_fault == 1'b0, "R1", {30'd0, r_inwin, r_fault}, 32'd0);
    check(r_paddr == 32'h5000_1234 && lat == 1 && nrd == 0, "R1", r_paddr, 32'h5000_1234);

    // R11 busy during fetch
    @(negedge clk);
    req_valid = 1'b1; req_addr = va(9, 0);
    @(negedge clk);
    req_valid = 1'b0;
    check(stat_idle == 1'b0, "R11", 32'(stat_idle), 32'd0);
    repeat (5) @(negedge clk);
    check(stat_idle == 1'b1, "R11", 32'(stat_idle), 32'd1);
    full_flush();

    // sweep the whole table and a little past (R2 R3 R4 R5)
    for (int i = 0; i < NENT + 6; i++) begin
      expect_page(i, (i * 13) & 12'hFFF, (i >= NENT) ? "R2" : (valid_of(i) ? "R4" : "R5"));
      if (i >= NENT) begin
        check(nrd == 0 && lat == 1, "R2", 32'(nrd), 32'd0);
      end else begin
        check(nrd == 1 && last_maddr == TBL + 32'(i) * 4, "R3", last_maddr, TBL + 32'(i) * 4);
      end
    end

    // R6 and R7
    full_flush();
    expect_page(0, 1, "R6"); expect_page(1, 2, "R6");
    expect_page(2, 3, "R6"); expect_page(4, 4, "R6");
    for (int k = 0; k < 4; k++) begin
      automatic int p = (k == 3) ? 4 : k;
      expect_page(p, 100 + k, "R6");
      check(nrd == 0 && lat == 1, "R6", 32'(nrd * 100 + lat), 32'd1);
    end
    expect_page(5, 7, "R7");
    check(nrd == 1, "R7", 32'(nrd), 32'd1);
    expect_page(1, 8, "R7");
    check(nrd == 0, "R7", 32'(nrd), 32'd0);
    expect_page(0, 9, "R7");
    check(nrd == 1, "R7", 32'(nrd), 32'd1);

    // R5 invalid entries never cached
    expect_page(3, 0, "R5");
    expect_page(3, 0, "R5");
    check(nrd == 1, "R5", 32'(nrd), 32'd1);

    // R8 invalidate
    expect_page(6, 0, "R8");
    cfg_write(2'd2, 32'h0000_0101);
    expect_page(6, 0, "R8");
    check(nrd == 1, "R8", 32'(nrd), 32'd1);

    // R9 secondary reset
    expect_page(6, 5, "R9");
    check(nrd == 0, "R9", 32'(nrd), 32'd0);
    cfg_write(2'd2, 32'h0001_0100);
    expect_page(6, 5, "R9");
    check(nrd == 1, "R9", 32'(nrd), 32'd1);

    // R12 flush during pending fetch
    cfg_write(2'd2, 32'h0000_0101);
    @(negedge clk);
    req_valid = 1'b1; req_addr = va(8, 16);
    @(negedge clk);
    req_valid = 1'b0;
    cfg_we = 1'b1; cfg_sel = 2'd2; cfg_wdata = 32'h0000_0101;
    @(negedge clk);
    cfg_we = 1'b0;
    lat = 0;
    while (!rsp_valid && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    check(rsp_valid && !rsp_fault && rsp_paddr == {frame_of(8), 12'd16}, "R12", rsp_paddr, {frame_of(8), 12'd16});
    expect_page(8, 16, "R12");
    check(nrd == 1, "R12", 32'(nrd), 32'd1);

    // shutdown sequence then R10
    cfg_write(2'd2, 32'h0000_0101);
    cfg_write(2'd2, 32'h0000_0000);
    cfg_write(2'd2, 32'h0001_0000);
    cfg_write(2'd2, 32'h0000_0000);
    access(va(8, 16));
    check(r_fault == 1'b1 && nrd == 0, "R10", {31'd0, r_fault}, 32'd1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule